// File: doc/BRIEF.md
# Quad-Lane Double-Edge Sample Serializer

This block turns four parallel sample words into four serial lanes, one lane per channel. It runs on a fast bit clock at eight times the sample rate and sends one bit per bit-clock cycle, most significant bit first. Alongside the lanes it drives two timing outputs. The first is a data clock that toggles once per bit, so it runs at four times the sample rate and every one of its edges launches a bit. The second is a frame clock at the sample rate whose rising edge marks the first bit of each byte. Before serialization each sample may be clamped because its channel is out of range, and it may be recoded from offset binary to two's complement.

Samples enter through a valid/ready stream that carries all four channels in one beat. `s_ready` is high only in the last bit period before a byte starts, and only while the clock source reports lock. A beat transfers on a rising edge where both `s_valid` and `s_ready` are high. While `s_valid` is high and `s_ready` is low, the producer must hold `s_data`, `s_ovr`, `s_ovr_hi` and `fmt_twos` stable. If no beat is offered at a byte boundary, the block sends an all-zero byte and keeps the frame timing running.

If the lock input drops, the lock flag rises in the same cycle. The lanes, the data clock and the frame clock freeze, and the rest of the current byte is discarded. When lock returns, a new byte starts from its first bit.

Top module: `qlane_tx`

## Requirements
- R1: Each lane sends its accepted byte MSB first, one bit per bit-clock cycle. The MSB is on the lane in the cycle after the accepting edge. In the sample word, channel c occupies `s_data[8c+7:8c]`.
- R2: While the block is running, `dclk_o` inverts on every bit-clock cycle, so a byte spans four data-clock periods.
- R3: `fclk_o` is high during bit periods 0 to 3 of a byte and low during bit periods 4 to 7. It rises only together with a freshly loaded MSB.
- R4: When `fmt_twos` is 0, the byte is sent in offset binary, which is the input word unchanged. When `fmt_twos` is 1, the byte is sent in two's complement, which is the input word with bit 7 inverted.
- R5: When `s_ovr[c]` is 1, channel c's byte is clamped before formatting. It becomes 8'hFF if `s_ovr_hi[c]` is 1 and 8'h00 otherwise. `ovr_o[c]` is then 1 for the whole byte. Otherwise `ovr_o[c]` is 0 for the byte.
- R6: `s_ready` is 1 only while `pll_lock` is 1 at a byte boundary. A boundary with no valid beat sends a zero byte on every lane, with all `ovr_o` bits 0.
- R7: `lock_n_o` is 0 only while `pll_lock` is 1 and the block has been running for at least one cycle. It goes to 1 in the same cycle that `pll_lock` falls.
- R8: While `pll_lock` is 0, `lane_o`, `dclk_o` and `fclk_o` hold their values, and the unsent bits of the interrupted byte are never sent.
- R9: In the first cycle in which `pll_lock` is 1 again, `s_ready` is 1. The next byte starts at its MSB with `fclk_o` high.
- R10: A synchronous active-high `rst` clears the lanes, `dclk_o`, `fclk_o` and `ovr_o` to 0, and holds `lock_n_o` at 1 and `s_ready` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, eight times the sample rate |
| rst | input | 1 | Synchronous active-high reset |
| pll_lock | input | 1 | 1 while the clock source is locked |
| fmt_twos | input | 1 | 0 = offset binary, 1 = two's complement; sampled with the beat |
| s_valid | input | 1 | Sample beat offered |
| s_ready | output | 1 | Beat accepted on the next rising edge |
| s_data | input | 32 | Four 8-bit samples, channel c at bits 8c+7:8c |
| s_ovr | input | 4 | Per-channel out-of-range flag |
| s_ovr_hi | input | 4 | Per-channel excursion direction, 1 = above range |
| lane_o | output | 4 | Serial lanes, bit c for channel c |
| dclk_o | output | 1 | Data clock, one edge per bit |
| fclk_o | output | 1 | Frame clock, high for the first half of each byte |
| lock_n_o | output | 1 | Active-low lock flag, 0 means the data is valid |
| ovr_o | output | 4 | Per-channel overrange flag for the byte on the lanes |

## Verification
Two pairs of functions can land in the same cycle. The first pair is clamping and format recoding: the bench offers beats in which one channel is out of range while two's complement is selected. It expects 8'h7F for a high excursion and 8'h80 for a low one, and the overrange flag must stay up for the whole byte. The second pair is loss of lock and a byte in flight: the lock input is dropped on the third bit of a known byte. The bench expects the lock flag high in that same cycle, the lanes and both clocks frozen, and, once lock returns, a fresh byte whose MSB coincides with a high frame clock and with the scoreboard's next expected item.

// File: rtl/qlane_pkg.sv
package qlane_pkg;
  localparam int QL_CHANNELS = 4;
  localparam int QL_SAMPLE_W = 8;

  typedef enum logic {
    FMT_OFFSET = 1'b0,
    FMT_TWOS   = 1'b1
  } fmt_e;
endpackage

// File: rtl/qlane_fmt.sv
// Clamp then recode one channel's sample; purely combinational.
module qlane_fmt #(
  parameter int W = qlane_pkg::QL_SAMPLE_W
) (
  input  logic [W-1:0]      raw,
  input  logic              ovr,
  input  logic              ovr_hi,
  input  qlane_pkg::fmt_e   fmt,
  output logic [W-1:0]      code
);
  logic [W-1:0] clamped;

  always_comb begin
    if (ovr) clamped = ovr_hi ? {W{1'b1}} : {W{1'b0}};
    else     clamped = raw;
    code = clamped;
    if (fmt == qlane_pkg::FMT_TWOS) code[W-1] = ~clamped[W-1];
  end
endmodule

// File: rtl/qlane_lane.sv
// One serial lane: load a word, then shift it out MSB first.
module qlane_lane #(
  parameter int W = qlane_pkg::QL_SAMPLE_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic         shift,
  input  logic [W-1:0] din,
  output logic         bit_o
);
  logic [W-1:0] sh_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q  <= '0;
      bit_o <= 1'b0;
    end else if (load) begin
      bit_o <= din[W-1];
      sh_q  <= {din[W-2:0], 1'b0};
    end else if (shift) begin
      bit_o <= sh_q[W-1];
      sh_q  <= {sh_q[W-2:0], 1'b0};
    end
  end
endmodule

// File: rtl/qlane_timing.sv
// Bit counter, data/frame clocks, lock flag and stream handshake.
module qlane_timing #(
  parameter int W = qlane_pkg::QL_SAMPLE_W
) (
  input  logic clk,
  input  logic rst,
  input  logic pll_lock,
  output logic load_o,
  output logic shift_o,
  output logic ready_o,
  output logic lock_n_o,
  output logic dclk_o,
  output logic fclk_o
);
  localparam int CW   = (W > 2) ? $clog2(W) : 1;
  localparam int HALF = W / 2;

  logic [CW-1:0] cnt_q;
  logic          run_q;
  logic          at_start;

  assign at_start = (cnt_q == '0);
  assign load_o   = pll_lock && at_start;
  assign shift_o  = pll_lock && !at_start;
  assign ready_o  = load_o && !rst;
  assign lock_n_o = !(pll_lock && run_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      run_q  <= 1'b0;
      dclk_o <= 1'b0;
      fclk_o <= 1'b0;
    end else if (!pll_lock) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else begin
      run_q  <= 1'b1;
      dclk_o <= ~dclk_o;
      fclk_o <= (int'(cnt_q) < HALF);
      cnt_q  <= (cnt_q == CW'(W - 1)) ? '0 : cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/qlane_tx.sv
module qlane_tx #(
  parameter int CH = qlane_pkg::QL_CHANNELS,
  parameter int W  = qlane_pkg::QL_SAMPLE_W
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            pll_lock,
  input  logic            fmt_twos,
  input  logic            s_valid,
  output logic            s_ready,
  input  logic [CH*W-1:0] s_data,
  input  logic [CH-1:0]   s_ovr,
  input  logic [CH-1:0]   s_ovr_hi,
  output logic [CH-1:0]   lane_o,
  output logic            dclk_o,
  output logic            fclk_o,
  output logic            lock_n_o,
  output logic [CH-1:0]   ovr_o
);
  logic load, shift;

  qlane_timing #(.W(W)) u_timing (
    .clk(clk), .rst(rst), .pll_lock(pll_lock),
    .load_o(load), .shift_o(shift), .ready_o(s_ready),
    .lock_n_o(lock_n_o), .dclk_o(dclk_o), .fclk_o(fclk_o)
  );

  for (genvar c = 0; c < CH; c++) begin : g_ch
    logic [W-1:0] code;
    logic [W-1:0] din;

    qlane_fmt #(.W(W)) u_fmt (
      .raw(s_data[c*W +: W]), .ovr(s_ovr[c]), .ovr_hi(s_ovr_hi[c]),
      .fmt(qlane_pkg::fmt_e'(fmt_twos)), .code(code)
    );

    // Idle boundary sends a zero byte
    assign din = s_valid ? code : '0;

    qlane_lane #(.W(W)) u_lane (
      .clk(clk), .rst(rst), .load(load), .shift(shift),
      .din(din), .bit_o(lane_o[c])
    );

    always_ff @(posedge clk) begin
      if (rst)       ovr_o[c] <= 1'b0;
      else if (load) ovr_o[c] <= s_valid && s_ovr[c];
    end
  end
endmodule

// File: rtl/qlane_tx_chk.sv
module qlane_tx_chk #(
  parameter int CH = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          pll_lock,
  input logic          s_ready,
  input logic [CH-1:0] lane_o,
  input logic          dclk_o,
  input logic          fclk_o,
  input logic          lock_n_o,
  input logic [CH-1:0] ovr_o
);
  // R2
  dclk_toggle_chk: assert property (@(posedge clk) disable iff (rst)
    pll_lock |=> (dclk_o != $past(dclk_o)));

  // R3
  fclk_rise_on_load_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(fclk_o) |-> $past(s_ready));

  // R5
  ovr_change_on_load_chk: assert property (@(posedge clk) disable iff (rst)
    (ovr_o != $past(ovr_o)) |-> $past(s_ready));

  // R7
  lock_flag_drop_chk: assert property (@(posedge clk) disable iff (rst)
    !pll_lock |-> lock_n_o);

  // R8
  freeze_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !pll_lock |=> ($stable(lane_o) && $stable(dclk_o) && $stable(fclk_o)));
endmodule

bind qlane_tx qlane_tx_chk #(.CH(CH)) u_chk (
  .clk(clk), .rst(rst), .pll_lock(pll_lock), .s_ready(s_ready),
  .lane_o(lane_o), .dclk_o(dclk_o), .fclk_o(fclk_o),
  .lock_n_o(lock_n_o), .ovr_o(ovr_o)
);

// File: tb/sim_qlane_tx.sv
module sim_qlane_tx;
  localparam int CH = 4;
  localparam int W  = 8;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic            rst, pll_lock, fmt_twos, s_valid;
  logic [CH*W-1:0] s_data;
  logic [CH-1:0]   s_ovr, s_ovr_hi;
  wire             s_ready, dclk_o, fclk_o, lock_n_o;
  wire  [CH-1:0]   lane_o, ovr_o;

  qlane_tx #(.CH(CH), .W(W)) u0 (
    .clk(clk), .rst(rst), .pll_lock(pll_lock), .fmt_twos(fmt_twos),
    .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data),
    .s_ovr(s_ovr), .s_ovr_hi(s_ovr_hi), .lane_o(lane_o),
    .dclk_o(dclk_o), .fclk_o(fclk_o), .lock_n_o(lock_n_o), .ovr_o(ovr_o)
  );

  int checks = 0, fails = 0;
  bit mon_en = 0, done = 0;
  logic [CH*W-1:0] q_data[$];
  logic [CH-1:0]   q_ovr[$];

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  function automatic logic [W-1:0] exp_code(logic [W-1:0] raw, logic o, logic hi, logic tw);
    logic [W-1:0] v;
    v = o ? (hi ? 8'hFF : 8'h00) : raw;
    if (tw) v[W-1] = ~v[W-1];
    return v;
  endfunction

  // Driver: called at a falling edge; pushes the expected bytes on acceptance
  task automatic send(input logic [CH*W-1:0] d, input logic [CH-1:0] o,
                      input logic [CH-1:0] hi, input logic tw);
    logic [CH*W-1:0] e;
    s_data = d; s_ovr = o; s_ovr_hi = hi; fmt_twos = tw; s_valid = 1'b1;
    while (!s_ready) @(negedge clk);
    for (int c = 0; c < CH; c++) e[c*W +: W] = exp_code(d[c*W +: W], o[c], hi[c], tw);
    q_data.push_back(e);
    q_ovr.push_back(o);
    @(negedge clk);
    s_valid = 1'b0;
  endtask

  // Monitor: collects each accepted byte and compares with the scoreboard
  initial begin
    @(negedge clk); #1;
    forever begin
      if (mon_en && s_valid && s_ready) begin
        logic [CH*W-1:0] got;
        logic [CH-1:0]   got_ovr;
        logic            prev_d;
        got = '0; got_ovr = '0; prev_d = dclk_o;
        for (int i = 0; i < W; i++) begin
          @(negedge clk); #1;
          for (int c = 0; c < CH; c++) got[c*W + W - 1 - i] = lane_o[c];
          chk(fclk_o == (i < W/2), "R3 R9 frame clock phase", fclk_o, i < W/2);
          chk(dclk_o != prev_d, "R2 data clock toggle", dclk_o, !prev_d);
          prev_d = dclk_o;
          if (i == 0) got_ovr = ovr_o;
          else chk(ovr_o == got_ovr, "R5 overrange held for byte", ovr_o, got_ovr);
        end
        if (q_data.size() == 0) chk(0, "R1 unexpected byte", got, 0);
        else begin
          logic [CH*W-1:0] e;
          logic [CH-1:0]   eo;
          e = q_data.pop_front();
          eo = q_ovr.pop_front();
          chk(got == e, "R1 R4 R5 lane bytes", got, e);
          chk(got_ovr == eo, "R5 overrange flags", got_ovr, eo);
        end
      end else begin
        @(negedge clk); #1;
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      summary();
    end
  end

  initial begin
    logic [CH+2:0] held;
    bit idle_ok;
    rst = 1; pll_lock = 0; fmt_twos = 0; s_valid = 0;
    s_data = '0; s_ovr = '0; s_ovr_hi = '0;
    repeat (3) @(negedge clk);
    chk(lane_o == 0 && dclk_o == 0 && fclk_o == 0, "R10 reset outputs", {lane_o, dclk_o, fclk_o}, 0);
    chk(ovr_o == 0, "R10 reset overrange", ovr_o, 0);
    chk(lock_n_o == 1 && s_ready == 0, "R10 reset lock and ready", {lock_n_o, s_ready}, 2'b10);
    rst = 0;
    @(negedge clk);
    chk(lock_n_o == 1, "R7 unlocked after reset", lock_n_o, 1);
    chk(s_ready == 0, "R6 no ready without lock", s_ready, 0);

    pll_lock = 1; #1;
    chk(s_ready == 1, "R9 ready on first locked cycle", s_ready, 1);
    chk(lock_n_o == 1, "R7 flag waits one cycle", lock_n_o, 1);
    @(negedge clk);
    chk(lock_n_o == 0, "R7 locked flag low", lock_n_o, 0);
    mon_en = 1;
    while (!s_ready) @(negedge clk);
    send(32'h80_7F_00_FF, 4'b0000, 4'b0000, 1'b0);
    send(32'h12_34_56_78, 4'b0000, 4'b0000, 1'b1);
    send(32'hAA_55_C3_3C, 4'b0101, 4'b0001, 1'b0);
    send(32'h01_FE_90_09, 4'b1010, 4'b1000, 1'b1);
    while (q_data.size() != 0) @(negedge clk);

    // R6: idle boundaries send zero bytes
    repeat (2*W) @(negedge clk);
    idle_ok = 1;
    for (int i = 0; i < W; i++) begin
      @(negedge clk);
      if (lane_o != 0 || ovr_o != 0) idle_ok = 0;
    end
    chk(idle_ok, "R6 idle zero bytes", idle_ok, 1);

    // R8: lose lock on the third bit of 8'hA5 (1010_0101)
    mon_en = 0;
    while (!s_ready) @(negedge clk);
    s_data = {CH{8'hA5}}; s_ovr = '0; fmt_twos = 0; s_valid = 1;
    @(negedge clk); s_valid = 0;
    chk(lane_o == 4'hF && fclk_o == 1, "R1 MSB with frame high", {lane_o, fclk_o}, 5'h1F);
    @(negedge clk);
    chk(lane_o == 4'h0, "R1 second bit", lane_o, 0);
    @(negedge clk);
    chk(lane_o == 4'hF, "R1 third bit", lane_o, 4'hF);
    pll_lock = 0; #1;
    chk(lock_n_o == 1, "R7 flag high at once", lock_n_o, 1);
    chk(s_ready == 0, "R6 no ready while unlocked", s_ready, 0);
    held = {lane_o, dclk_o, fclk_o};
    repeat (6) @(negedge clk);
    chk({lane_o, dclk_o, fclk_o} == held, "R8 outputs frozen", {lane_o, dclk_o, fclk_o}, held);

    pll_lock = 1; #1;
    chk(s_ready == 1, "R9 ready at relock", s_ready, 1);
    @(negedge clk);
    mon_en = 1;
    while (!s_ready) @(negedge clk);
    send(32'h3C_C3_01_80, 4'b0000, 4'b0000, 1'b0);
    while (q_data.size() != 0) @(negedge clk);
    chk(lock_n_o == 0, "R7 locked after restart", lock_n_o, 0);
    repeat (2) @(negedge clk);
    summary();
  end
endmodule